// File: doc/BRIEF.md
# Delayed Write Completion Parity Handler

This block sits on the initiator-side port of a bridge that turns writes into delayed transactions. It keeps the delayed write at the head of the queue, together with the target-bus parity status that came back with the write's completion. It then watches each repeated write attempt from the initiator. A retry whose address, command, data and byte enables all equal the held entry finishes the delayed write. A retry that differs in any of these fields is told to retry again. The parity bit that travels with a retry plays no part in this comparison.

A matching retry can carry a parity error that the initiator-side checker flagged. In that case the block still acknowledges the data phase, but it keeps the entry queued and sets the sticky parity-error-detected flag of the initiating interface. Two cycles after the acknowledge it pulses the active-low parity-error output, provided that interface's response enable is set. A matching retry without a local error can find an error that was forwarded from the target bus. It then completes normally and pulses the parity-error output two cycles after the acknowledge, but only when both response enables are set. A direction bit held with the entry selects which interface counts as the initiator: primary for downstream, secondary for upstream.

Top module: `dwr_parity_ctl`

## Requirements
- R1: When an entry is held (head_valid=1) and a retry strobe carries the same address, command, data and byte enables, ack_o is high for one cycle in the cycle after the strobe. If the retry has no initiator-side parity error, head_pop is high in that same cycle and head_valid is 0 from then on.
- R2: A retry strobe while no entry is held, or one where any of address, command, data or byte enables differs, gives retry_o=1 for one cycle in the cycle after the strobe, with ack_o=0 and head_pop=0. The held entry is unchanged and can still be completed later.
- R3: The retry parity bit (rty_par) and the stored entry parity bit (ent_par) are not compared. A retry that differs from the entry only in that bit completes as in R1.
- R4: A matching retry with rty_par_err=1 gets ack_o=1 but head_pop=0, and head_valid stays 1.
- R5: For a matching retry with rty_par_err=1, par_err_n is low exactly two cycles after the ack_o cycle. This happens only if the initiator's response enable, sampled with the strobe, is 1: pri_resp_en when ent_dir=0 (downstream), sec_resp_en when ent_dir=1 (upstream).
- R6: A matching retry with rty_par_err=1 sets pri_perr_det when ent_dir=0 and sec_perr_det when ent_dir=1, whatever the enables, in the ack_o cycle. The other flag is untouched. rty_par_err on a non-matching retry has no effect.
- R7: A matching retry with rty_par_err=0 on an entry loaded with ent_tgt_perr=1 completes and pops as in R1. par_err_n is low two cycles after ack_o only when pri_resp_en and sec_resp_en are both 1.
- R8: The detected flags are sticky. A pulse on pri_sts_clr or sec_sts_clr clears its flag in the next cycle. A set and a clear in the same cycle leave the flag set.
- R9: After reset, head_valid, ack_o, retry_o, head_pop and both detected flags are 0, and par_err_n is 1.
- R10: par_err_n goes low for exactly one cycle per signalled error and is 1 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_load | input | 1 | Load a new head entry |
| ent_dir | input | 1 | Entry direction: 0 downstream, 1 upstream |
| ent_addr | input | AW | Entry address |
| ent_cmd | input | CW | Entry command |
| ent_data | input | DW | Entry data |
| ent_be | input | DW/8 | Entry byte enables |
| ent_par | input | 1 | Entry parity bit (stored, never compared) |
| ent_tgt_perr | input | 1 | Parity error forwarded from the target bus |
| rty_valid | input | 1 | Retry data-phase strobe |
| rty_addr | input | AW | Retry address |
| rty_cmd | input | CW | Retry command |
| rty_data | input | DW | Retry data |
| rty_be | input | DW/8 | Retry byte enables |
| rty_par | input | 1 | Retry parity bit |
| rty_par_err | input | 1 | Initiator-side parity error on this retry |
| pri_resp_en | input | 1 | Primary parity-error response enable |
| sec_resp_en | input | 1 | Secondary parity-error response enable |
| pri_sts_clr | input | 1 | Write-one-to-clear for the primary detected flag |
| sec_sts_clr | input | 1 | Write-one-to-clear for the secondary detected flag |
| ack_o | output | 1 | Target-ready acknowledge of a retry |
| retry_o | output | 1 | Retry response to a non-matching attempt |
| head_pop | output | 1 | Head entry retired |
| head_valid | output | 1 | Head entry held |
| par_err_n | output | 1 | Active-low parity-error pulse |
| pri_perr_det | output | 1 | Primary parity-error-detected flag |
| sec_perr_det | output | 1 | Secondary parity-error-detected flag |

## Verification
A wrong comparison shows at the ports one cycle after the strobe: ack_o and retry_o swap, or head_pop appears on a retry that carried a parity error. A stale head_valid also shows there, or on the next retry that should have matched. A wrong direction or enable selection shows first in the detected flags in the ack cycle, and two cycles later as a par_err_n pulse that is missing, misplaced or extra. The bench checks par_err_n in each of the four cycles after every retry, so a shifted delay is caught within that window.

// File: rtl/dwr_parity_ctl.sv
module dwr_parity_ctl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_load,
  input  logic            ent_dir,
  input  logic [AW-1:0]   ent_addr,
  input  logic [CW-1:0]   ent_cmd,
  input  logic [DW-1:0]   ent_data,
  input  logic [DW/8-1:0] ent_be,
  input  logic            ent_par,
  input  logic            ent_tgt_perr,
  input  logic            rty_valid,
  input  logic [AW-1:0]   rty_addr,
  input  logic [CW-1:0]   rty_cmd,
  input  logic [DW-1:0]   rty_data,
  input  logic [DW/8-1:0] rty_be,
  input  logic            rty_par,
  input  logic            rty_par_err,
  input  logic            pri_resp_en,
  input  logic            sec_resp_en,
  input  logic            pri_sts_clr,
  input  logic            sec_sts_clr,
  output logic            ack_o,
  output logic            retry_o,
  output logic            head_pop,
  output logic            head_valid,
  output logic            par_err_n,
  output logic            pri_perr_det,
  output logic            sec_perr_det
);
  localparam int BW = DW / 8;

  logic [AW-1:0] h_addr;
  logic [CW-1:0] h_cmd;
  logic [DW-1:0] h_data;
  logic [BW-1:0] h_be;
  logic          h_dir, h_tgt_perr, h_par;
  logic          sig_d1, sig_d2;

  // parity bit deliberately excluded from the match
  wire hit      = head_valid && rty_valid && (rty_addr == h_addr) &&
                  (rty_cmd == h_cmd) && (rty_data == h_data) && (rty_be == h_be);
  wire ini_err  = hit && rty_par_err;
  wire ini_en   = h_dir ? sec_resp_en : pri_resp_en;
  wire sig_now  = hit && (rty_par_err ? ini_en
                                      : (h_tgt_perr && pri_resp_en && sec_resp_en));
  wire set_pri  = ini_err && !h_dir;
  wire set_sec  = ini_err &&  h_dir;
  wire unused_par = h_par ^ rty_par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr     <= '0;
      h_cmd      <= '0;
      h_data     <= '0;
      h_be       <= '0;
      h_dir      <= 1'b0;
      h_tgt_perr <= 1'b0;
      h_par      <= 1'b0;
    end else if (ent_load) begin
      h_addr     <= ent_addr;
      h_cmd      <= ent_cmd;
      h_data     <= ent_data;
      h_be       <= ent_be;
      h_dir      <= ent_dir;
      h_tgt_perr <= ent_tgt_perr;
      h_par      <= ent_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_valid   <= 1'b0;
      ack_o        <= 1'b0;
      retry_o      <= 1'b0;
      head_pop     <= 1'b0;
      sig_d1       <= 1'b0;
      sig_d2       <= 1'b0;
      par_err_n    <= 1'b1;
      pri_perr_det <= 1'b0;
      sec_perr_det <= 1'b0;
    end else begin
      if (ent_load)
        head_valid <= 1'b1;
      else if (hit && !rty_par_err)
        head_valid <= 1'b0;
      ack_o        <= hit;
      retry_o      <= rty_valid && !hit;
      head_pop     <= hit && !rty_par_err;
      sig_d1       <= sig_now;
      sig_d2       <= sig_d1;
      par_err_n    <= !sig_d2;
      pri_perr_det <= set_pri || (pri_perr_det && !pri_sts_clr);
      sec_perr_det <= set_sec || (sec_perr_det && !sec_sts_clr);
    end
  end

  AST_ACK_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && retry_o));                                                    // R2
  AST_POP_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    head_pop |-> ack_o);                                                     // R1
  AST_LOCAL_ERR_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rty_valid && rty_par_err) |=> !head_pop);                               // R4
  AST_EMPTY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rty_valid && !head_valid) |=> retry_o);                                 // R2
  AST_ERR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !par_err_n |-> $past(ack_o, 2));                                         // R5
  AST_FLAG_STICKY_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_perr_det && !pri_sts_clr) |=> pri_perr_det);                        // R8
  AST_FLAG_STICKY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_perr_det && !sec_sts_clr) |=> sec_perr_det);                        // R8
  AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_err_n) |-> ($past(pri_resp_en, 3) || $past(sec_resp_en, 3))); // R5
endmodule

// File: tb/dwr_parity_ctl_tb.sv
module dwr_parity_ctl_tb;
  localparam int AW = 32, DW = 32, CW = 4, BW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ent_load = 0, ent_dir = 0, ent_par = 0, ent_tgt_perr = 0;
  logic [AW-1:0] ent_addr = '0, rty_addr = '0;
  logic [CW-1:0] ent_cmd = '0, rty_cmd = '0;
  logic [DW-1:0] ent_data = '0, rty_data = '0;
  logic [BW-1:0] ent_be = '0, rty_be = '0;
  logic rty_valid = 0, rty_par = 0, rty_par_err = 0;
  logic pri_resp_en = 0, sec_resp_en = 0, pri_sts_clr = 0, sec_sts_clr = 0;
  logic ack_o, retry_o, head_pop, head_valid, par_err_n, pri_perr_det, sec_perr_det;

  int checks = 0, errors = 0;
  logic m_valid = 0, m_dir = 0, m_tgt = 0, m_pri = 0, m_sec = 0;
  logic [AW-1:0] m_addr;
  logic [CW-1:0] m_cmd;
  logic [DW-1:0] m_data;
  logic [BW-1:0] m_be;

  always #2 clk = ~clk;

  dwr_parity_ctl #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_hit(logic [AW-1:0] a, logic [CW-1:0] c,
                                   logic [DW-1:0] d, logic [BW-1:0] b);
    return m_valid && a == m_addr && c == m_cmd && d == m_data && b == m_be;
  endfunction

  function automatic logic exp_sig(logic hit, logic perr, logic pe, logic se);
    if (!hit) return 1'b0;
    if (perr) return m_dir ? se : pe;
    return m_tgt && pe && se;
  endfunction

  task automatic load(logic dir, logic [AW-1:0] a, logic [CW-1:0] c,
                      logic [DW-1:0] d, logic [BW-1:0] b, logic tgt, logic par);
    @(negedge clk);
    ent_load = 1; ent_dir = dir; ent_addr = a; ent_cmd = c; ent_data = d;
    ent_be = b; ent_tgt_perr = tgt; ent_par = par;
    @(negedge clk);
    ent_load = 0;
    m_valid = 1; m_dir = dir; m_addr = a; m_cmd = c; m_data = d; m_be = b; m_tgt = tgt;
    chk("R1 head_valid after load", head_valid, 1'b1);
  endtask

  task automatic retry(logic [AW-1:0] a, logic [CW-1:0] c, logic [DW-1:0] d,
                       logic [BW-1:0] b, logic par, logic perr, logic pe, logic se,
                       logic cp, logic cs);
    logic hit, sig;
    hit = exp_hit(a, c, d, b);
    sig = exp_sig(hit, perr, pe, se);
    @(negedge clk);
    rty_valid = 1; rty_addr = a; rty_cmd = c; rty_data = d; rty_be = b;
    rty_par = par; rty_par_err = perr; pri_resp_en = pe; sec_resp_en = se;
    pri_sts_clr = cp; sec_sts_clr = cs;
    @(negedge clk);
    rty_valid = 0; rty_par_err = 0; pri_sts_clr = 0; sec_sts_clr = 0;
    m_pri = (hit && perr && !m_dir) || (m_pri && !cp);
    m_sec = (hit && perr &&  m_dir) || (m_sec && !cs);
    if (hit && !perr) m_valid = 0;
    chk("R1 ack_o", ack_o, hit);
    chk("R2 retry_o", retry_o, !hit);
    chk("R4 head_pop", head_pop, hit && !perr);
    chk("R1 head_valid", head_valid, m_valid);
    chk("R6 pri_perr_det", pri_perr_det, m_pri);
    chk("R6 sec_perr_det", sec_perr_det, m_sec);
    chk("R10 par_err_n idle +1", par_err_n, 1'b1);
    @(negedge clk);
    chk("R10 par_err_n idle +2", par_err_n, 1'b1);
    @(negedge clk);
    chk("R5 R7 par_err_n at +3", par_err_n, !sig);
    @(negedge clk);
    chk("R10 par_err_n released", par_err_n, 1'b1);
  endtask

  task automatic clr(logic cp, logic cs);
    @(negedge clk);
    pri_sts_clr = cp; sec_sts_clr = cs;
    @(negedge clk);
    pri_sts_clr = 0; sec_sts_clr = 0;
    if (cp) m_pri = 0;
    if (cs) m_sec = 0;
    chk("R8 pri clear", pri_perr_det, m_pri);
    chk("R8 sec clear", sec_perr_det, m_sec);
  endtask

  initial begin
    logic [AW-1:0] a; logic [CW-1:0] c; logic [DW-1:0] d; logic [BW-1:0] b;
    void'($urandom(32'd20240607));
    #10; rst_n = 1;
    @(negedge clk);
    chk("R9 head_valid", head_valid, 0);
    chk("R9 ack_o", ack_o, 0);
    chk("R9 retry_o", retry_o, 0);
    chk("R9 head_pop", head_pop, 0);
    chk("R9 par_err_n", par_err_n, 1);
    chk("R9 pri flag", pri_perr_det, 0);
    chk("R9 sec flag", sec_perr_det, 0);

    // R2: empty queue, with an error flag that must be ignored (R6)
    retry(32'h10, 4'h7, 32'hAA, 4'hF, 0, 1, 1, 1, 0, 0);
    // R2 mismatch keeps entry, then R4/R5/R6 downstream local error
    load(0, 32'h1000, 4'h7, 32'hDEAD_BEEF, 4'hF, 0, 1);
    retry(32'h1004, 4'h7, 32'hDEAD_BEEF, 4'hF, 1, 1, 1, 1, 0, 0);
    retry(32'h1000, 4'h7, 32'hDEAD_BEEF, 4'hF, 0, 1, 1, 0, 0, 0);
    // R3: parity bit differs, still completes
    retry(32'h1000, 4'h7, 32'hDEAD_BEEF, 4'hF, 0, 0, 1, 1, 0, 0);
    // upstream local error with secondary enable off: flag only (R6, R5)
    load(1, 32'h2000, 4'h6, 32'h1234_5678, 4'h3, 0, 0);
    retry(32'h2000, 4'h6, 32'h1234_5678, 4'h3, 0, 1, 1, 0, 0, 0);
    // R8 set wins over clear on the secondary flag
    retry(32'h2000, 4'h6, 32'h1234_5678, 4'h3, 1, 1, 0, 1, 0, 1);
    clr(1, 0);
    clr(0, 1);
    // R7 forwarded target error: needs both enables
    retry(32'h2000, 4'h6, 32'h1234_5678, 4'h2, 0, 0, 1, 1, 0, 0);
    load(0, 32'h3000, 4'h7, 32'h0, 4'h1, 1, 0);
    retry(32'h3000, 4'h7, 32'h0, 4'h1, 0, 0, 1, 0, 0, 0);
    load(1, 32'h3000, 4'h7, 32'h0, 4'h1, 1, 0);
    retry(32'h3000, 4'h7, 32'h0, 4'h1, 1, 0, 1, 1, 0, 0);

    for (int i = 0; i < 400; i++) begin
      if (!m_valid || $urandom_range(0, 5) == 0)
        load($urandom_range(0, 1), $urandom, $urandom, $urandom, $urandom,
             $urandom_range(0, 1), $urandom_range(0, 1));
      a = m_addr; c = m_cmd; d = m_data; b = m_be;
      case ($urandom_range(0, 7))
        0: a ^= AW'(1) << $urandom_range(0, AW - 1);
        1: c ^= CW'(1) << $urandom_range(0, CW - 1);
        2: d ^= DW'(1) << $urandom_range(0, DW - 1);
        3: b ^= BW'(1) << $urandom_range(0, BW - 1);
        default: ;
      endcase
      retry(a, c, d, b, $urandom_range(0, 1), $urandom_range(0, 3) == 0,
            $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule